// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block moves outgoing frames from system memory to a byte stream. Software builds a ring of 8-byte transmit descriptors, sets the ring base and pulses the activate strobe while the controller is enabled. The walker then reads descriptors from the current pointer onward and copies each ready descriptor's data buffer into an on-chip frame store. A frame may be spread over several descriptors. When the walker reaches a descriptor marked last-in-frame, it plays the stored frame out on a valid/ready byte stream.

Each processed descriptor is written back with its ready flag cleared. Single-cycle event pulses report a finished buffer, a finished frame and a truncated (babbling) frame. The ring closes through a per-descriptor wrap flag rather than through a fixed entry count. The walker stops at the first descriptor that software has not handed over, and it keeps its pointer there for the next activation.

Descriptor layout is one 32-bit word at the descriptor address and one at address + 4. In the first word, bits 15:0 hold the buffer byte count and bits 31:16 the flags. Within that word, bit 31 is ready, bit 29 is wrap and bit 27 is last. The second word is the byte address of the data buffer. Bytes sit little-endian within memory words.

Top module: `txring_engine`

## Requirements
- R1: A one-cycle pulse on `kick_i` while `enable_i` is 1 and the walker is idle starts a walk. The walk raises `busy_o` and reads the descriptor word at `cur_desc_o`.
- R2: The walk reads each descriptor's first word at the pointer and its buffer address at pointer + 4. When the first word has bit 31 (ready) clear, the walk ends, `busy_o` returns to 0 and `cur_desc_o` stays on that descriptor.
- R3: The walker reads the bytes at consecutive byte addresses from the buffer address, which may be unaligned, and appends them to the current frame. The bytes of successive descriptors without the last flag join into one frame.
- R4: A descriptor with bit 27 (last) set ends the frame. The walker sends every accumulated byte in order on the stream, with `tx_last_o` set on the final byte only, then empties the frame store and pulses `evt_frame_done_o` once.
- R5: When the accumulated length plus a descriptor's count would exceed MAX_FRAME (default 2048), the walker copies only enough bytes to reach MAX_FRAME and pulses `evt_babble_o`.
- R6: After its data is handled, each descriptor's first word is written back with bit 31 cleared and all other bits unchanged, and `evt_buf_done_o` pulses once.
- R7: After write-back, the next descriptor address is the ring base if bit 29 (wrap) was set, otherwise the current address + 8.
- R8: A write through `ring_base_we_i` stores the base with address bits 1:0 forced to 0. If the walker is idle, the write also loads `cur_desc_o`.
- R9: Whenever `enable_i` is 0 and the walker is idle, `cur_desc_o` returns to the ring base.
- R10: A `kick_i` pulse while `enable_i` is 0 is ignored: no memory request is issued and `busy_o` stays 0.
- R11: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_data_o` and `tx_last_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Controller enable level |
| kick_i | input | 1 | Activate strobe, one cycle |
| ring_base_we_i | input | 1 | Ring base write strobe |
| ring_base_i | input | 32 | Ring base value to write |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | 32 | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Single-cycle acknowledge |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final byte of frame |
| tx_ready_i | input | 1 | Stream sink ready |
| evt_buf_done_o | output | 1 | Pulse per written-back descriptor |
| evt_frame_done_o | output | 1 | Pulse per completed frame |
| evt_babble_o | output | 1 | Pulse when a frame is truncated |
| busy_o | output | 1 | Walk in progress |
| cur_desc_o | output | 32 | Current descriptor pointer |

## Verification
On every cycle the assertions check several local rules. Memory requests and stream bytes stay stable under stall, and write-backs never carry the ready flag. The descriptor pointer stays 4-byte aligned and lands on the ring base after a wrap. The frame store never takes a byte once it is full, and an idle walker leaves idle only on an enabled activate. Only the bench scenarios can show end-to-end behaviour. They check the byte order and last marker of gathered frames across unaligned buffers and the exact cut point of a truncated frame. They also check the write-back contents in memory, the event counts, and where the pointer rests after a stop, a wrap or a disable.

// File: rtl/txring_pkg.sv
package txring_pkg;
   localparam int ADDR_W      = 32;
   localparam int WORD_W      = 32;
   localparam int WORD_BYTES  = WORD_W / 8;
   localparam int LANE_SEL_W  = $clog2(WORD_BYTES);
   localparam int DESC_BYTES  = 8;
   localparam int LEN_W       = 16;
   localparam int RDY_BIT     = 31;
   localparam int WRAP_BIT    = 29;
   localparam int LAST_BIT    = 27;
   localparam logic [ADDR_W-1:0] ALIGN_MASK = 32'h0000_0003;

   typedef enum logic [2:0] {
      W_IDLE,
      W_RD0,
      W_RD1,
      W_COPY,
      W_DECIDE,
      W_SEND,
      W_WB
   } walk_state_e;
endpackage

// File: rtl/txring_ptr.sv
module txring_ptr
   import txring_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              idle_i,
   input  logic              base_we_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic              adv_i,
   input  logic              wrap_i,
   output logic [ADDR_W-1:0] base_o,
   output logic [ADDR_W-1:0] ptr_o
);
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] base_masked;

   assign base_masked = base_i & ~ALIGN_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         ptr_q  <= '0;
      end else begin
         if (base_we_i) base_q <= base_masked;
         if (base_we_i && idle_i)      ptr_q <= base_masked;
         else if (adv_i)               ptr_q <= wrap_i ? base_q : ptr_q + ADDR_W'(DESC_BYTES);
         else if (!enable_i && idle_i) ptr_q <= base_q;
      end
   end

   assign base_o = base_q;
   assign ptr_o  = ptr_q;

   assert_ptr_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_q & ALIGN_MASK) == '0);

   assert_wrap_to_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && wrap_i && !base_we_i) |=> (ptr_q == base_q));

   assert_disable_rewind_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable_i && idle_i && !adv_i && !base_we_i) |=> (ptr_q == base_q));
endmodule

// File: rtl/txring_fbuf.sv
module txring_fbuf #(
   parameter int MAX_FRAME = 2048,
   parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [7:0]       byte_i,
   input  logic             send_i,
   output logic [CNT_W-1:0] count_o,
   output logic             done_o,
   output logic             tx_valid_o,
   output logic [7:0]       tx_data_o,
   output logic             tx_last_o,
   input  logic             tx_ready_i
);
   localparam int IDX_W = (MAX_FRAME > 1) ? $clog2(MAX_FRAME) : 1;

   initial begin
      assert (MAX_FRAME >= 1) else $error("frame store needs at least one byte");
   end

   logic [7:0]       store [MAX_FRAME];
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] idx_q;
   logic             sending_q;
   logic             done_q;
   logic             fire;
   logic             at_end;

   assign at_end = (idx_q == count_q - CNT_W'(1));
   assign fire   = sending_q && tx_ready_i;

   always_ff @(posedge clk) begin
      if (wr_i) store[count_q[IDX_W-1:0]] <= byte_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q   <= '0;
         idx_q     <= '0;
         sending_q <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (wr_i) count_q <= count_q + CNT_W'(1);
         if (send_i) begin
            sending_q <= 1'b1;
            idx_q     <= '0;
         end else if (fire) begin
            if (at_end) begin
               sending_q <= 1'b0;
               count_q   <= '0;
               done_q    <= 1'b1;
            end else begin
               idx_q <= idx_q + CNT_W'(1);
            end
         end
      end
   end

   assign count_o    = count_q;
   assign done_o     = done_q;
   assign tx_valid_o = sending_q;
   assign tx_data_o  = store[idx_q[IDX_W-1:0]];
   assign tx_last_o  = sending_q && at_end;

   assert_store_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |-> (count_q < CNT_W'(MAX_FRAME)));

   assert_stream_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));

   assert_no_send_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      send_i |-> (count_q != '0 && !sending_q));
endmodule

// File: rtl/txring_walker.sv
module txring_walker
   import txring_pkg::*;
#(
   parameter int MAX_FRAME = 2048,
   parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              kick_i,
   input  logic [ADDR_W-1:0] desc_ptr_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [WORD_W-1:0] mem_wdata_o,
   input  logic [WORD_W-1:0] mem_rdata_i,
   input  logic              mem_ack_i,
   input  logic [CNT_W-1:0]  fb_count_i,
   output logic              fb_wr_o,
   output logic [7:0]        fb_byte_o,
   output logic              fb_send_o,
   input  logic              fb_done_i,
   output logic              adv_o,
   output logic              wrap_o,
   output logic              busy_o,
   output logic              evt_buf_o,
   output logic              evt_frame_o,
   output logic              evt_babble_o
);
   initial begin
      assert (MAX_FRAME < (1 << LEN_W)) else $error("frame limit must fit the length field");
   end

   walk_state_e       state_q;
   logic [WORD_W-1:0] w0_q;
   logic [ADDR_W-1:0] buf_ptr_q;
   logic [LEN_W-1:0]  remain_q;
   logic              evt_buf_q;
   logic              evt_frame_q;
   logic              evt_babble_q;

   logic [LEN_W-1:0]  space;
   logic [LEN_W-1:0]  want;
   logic [7:0]        lanes [WORD_BYTES];
   logic              is_last;

   assign space   = LEN_W'(MAX_FRAME) - LEN_W'(fb_count_i);
   assign want    = w0_q[LEN_W-1:0];
   assign is_last = w0_q[LAST_BIT];

   for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
      assign lanes[g] = mem_rdata_i[8*g +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= W_IDLE;
         w0_q         <= '0;
         buf_ptr_q    <= '0;
         remain_q     <= '0;
         evt_buf_q    <= 1'b0;
         evt_frame_q  <= 1'b0;
         evt_babble_q <= 1'b0;
      end else begin
         evt_buf_q    <= 1'b0;
         evt_frame_q  <= 1'b0;
         evt_babble_q <= 1'b0;
         unique case (state_q)
            W_IDLE: if (kick_i && enable_i) state_q <= W_RD0;
            W_RD0: if (mem_ack_i) begin
               w0_q    <= mem_rdata_i;
               state_q <= mem_rdata_i[RDY_BIT] ? W_RD1 : W_IDLE;
            end
            W_RD1: if (mem_ack_i) begin
               buf_ptr_q <= mem_rdata_i;
               if (want > space) begin
                  remain_q     <= space;
                  evt_babble_q <= 1'b1;
                  state_q      <= (space == '0) ? W_DECIDE : W_COPY;
               end else begin
                  remain_q <= want;
                  state_q  <= (want == '0) ? W_DECIDE : W_COPY;
               end
            end
            W_COPY: if (mem_ack_i) begin
               buf_ptr_q <= buf_ptr_q + ADDR_W'(1);
               remain_q  <= remain_q - LEN_W'(1);
               if (remain_q == LEN_W'(1)) state_q <= W_DECIDE;
            end
            W_DECIDE: begin
               if (is_last && fb_count_i != '0) begin
                  state_q <= W_SEND;
               end else begin
                  if (is_last) evt_frame_q <= 1'b1;
                  state_q <= W_WB;
               end
            end
            W_SEND: if (fb_done_i) begin
               evt_frame_q <= 1'b1;
               state_q     <= W_WB;
            end
            W_WB: if (mem_ack_i) begin
               evt_buf_q <= 1'b1;
               state_q   <= W_RD0;
            end
            default: state_q <= W_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req_o  = 1'b0;
      mem_we_o   = 1'b0;
      mem_addr_o = desc_ptr_i;
      unique case (state_q)
         W_RD0:  mem_req_o = 1'b1;
         W_RD1: begin
            mem_req_o  = 1'b1;
            mem_addr_o = desc_ptr_i + ADDR_W'(WORD_BYTES);
         end
         W_COPY: begin
            mem_req_o  = 1'b1;
            mem_addr_o = buf_ptr_q & ~ALIGN_MASK;
         end
         W_WB: begin
            mem_req_o = 1'b1;
            mem_we_o  = 1'b1;
         end
         default: ;
      endcase
   end

   assign mem_wdata_o  = w0_q & ~(WORD_W'(1) << RDY_BIT);
   assign fb_wr_o      = (state_q == W_COPY) && mem_ack_i;
   assign fb_byte_o    = lanes[buf_ptr_q[LANE_SEL_W-1:0]];
   assign fb_send_o    = (state_q == W_DECIDE) && is_last && (fb_count_i != '0);
   assign adv_o        = (state_q == W_WB) && mem_ack_i;
   assign wrap_o       = w0_q[WRAP_BIT];
   assign busy_o       = (state_q != W_IDLE);
   assign evt_buf_o    = evt_buf_q;
   assign evt_frame_o  = evt_frame_q;
   assign evt_babble_o = evt_babble_q;

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == W_IDLE && !(kick_i && enable_i)) |=> (state_q == W_IDLE));

   assert_wb_no_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o) |-> !mem_wdata_o[RDY_BIT]);

   assert_mem_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

   assert_babble_after_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_babble_o |-> ($past(state_q) == W_RD1));

   assert_event_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_buf_o |=> !evt_buf_o);
endmodule

// File: rtl/txring_engine.sv
module txring_engine
   import txring_pkg::*;
#(
   parameter int MAX_FRAME = 2048
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        enable_i,
   input  logic        kick_i,
   input  logic        ring_base_we_i,
   input  logic [31:0] ring_base_i,
   output logic        mem_req_o,
   output logic        mem_we_o,
   output logic [31:0] mem_addr_o,
   output logic [31:0] mem_wdata_o,
   input  logic [31:0] mem_rdata_i,
   input  logic        mem_ack_i,
   output logic        tx_valid_o,
   output logic [7:0]  tx_data_o,
   output logic        tx_last_o,
   input  logic        tx_ready_i,
   output logic        evt_buf_done_o,
   output logic        evt_frame_done_o,
   output logic        evt_babble_o,
   output logic        busy_o,
   output logic [31:0] cur_desc_o
);
   localparam int CNT_W = $clog2(MAX_FRAME + 1);

   logic [ADDR_W-1:0] base_w;
   logic [ADDR_W-1:0] ptr_w;
   logic              adv_w;
   logic              wrap_w;
   logic              busy_w;
   logic [CNT_W-1:0]  count_w;
   logic              fb_wr_w;
   logic [7:0]        fb_byte_w;
   logic              fb_send_w;
   logic              fb_done_w;

   txring_ptr u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable_i  (enable_i),
      .idle_i    (!busy_w),
      .base_we_i (ring_base_we_i),
      .base_i    (ring_base_i),
      .adv_i     (adv_w),
      .wrap_i    (wrap_w),
      .base_o    (base_w),
      .ptr_o     (ptr_w)
   );

   txring_walker #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) u_walk (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable_i     (enable_i),
      .kick_i       (kick_i),
      .desc_ptr_i   (ptr_w),
      .mem_req_o    (mem_req_o),
      .mem_we_o     (mem_we_o),
      .mem_addr_o   (mem_addr_o),
      .mem_wdata_o  (mem_wdata_o),
      .mem_rdata_i  (mem_rdata_i),
      .mem_ack_i    (mem_ack_i),
      .fb_count_i   (count_w),
      .fb_wr_o      (fb_wr_w),
      .fb_byte_o    (fb_byte_w),
      .fb_send_o    (fb_send_w),
      .fb_done_i    (fb_done_w),
      .adv_o        (adv_w),
      .wrap_o       (wrap_w),
      .busy_o       (busy_w),
      .evt_buf_o    (evt_buf_done_o),
      .evt_frame_o  (evt_frame_done_o),
      .evt_babble_o (evt_babble_o)
   );

   txring_fbuf #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) u_fbuf (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (fb_wr_w),
      .byte_i     (fb_byte_w),
      .send_i     (fb_send_w),
      .count_o    (count_w),
      .done_o     (fb_done_w),
      .tx_valid_o (tx_valid_o),
      .tx_data_o  (tx_data_o),
      .tx_last_o  (tx_last_o),
      .tx_ready_i (tx_ready_i)
   );

   assign busy_o     = busy_w;
   assign cur_desc_o = ptr_w;

   assert_walk_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_w) |-> $past(enable_i && kick_i));

   assert_base_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (base_w & ALIGN_MASK) == '0);
endmodule

// File: tb/sim_txring_engine.sv
module sim_txring_engine;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable_i = 1'b0;
   logic        kick_i = 1'b0;
   logic        ring_base_we_i = 1'b0;
   logic [31:0] ring_base_i = '0;
   logic        mem_req_o, mem_we_o;
   logic [31:0] mem_addr_o, mem_wdata_o;
   logic [31:0] mem_rdata_i = '0;
   logic        mem_ack_i = 1'b0;
   logic        tx_valid_o, tx_last_o;
   logic [7:0]  tx_data_o;
   logic        tx_ready_i = 1'b0;
   logic        evt_buf_done_o, evt_frame_done_o, evt_babble_o, busy_o;
   logic [31:0] cur_desc_o;

   txring_engine u0 (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int n_req = 0;
   int n_txb = 0, n_txf = 0, n_bab = 0;
   int n_bytes = 0, n_frames = 0;
   int cyc = 0;
   bit finished = 0;
   logic [31:0] bmem [1024];
   logic [8:0]  exp_q [$];

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 7 + 3) & 255);
   endfunction

   // memory model: acknowledge one cycle after a request
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack_i <= 1'b0;
      end else begin
         if (mem_req_o) n_req++;
         mem_ack_i <= mem_req_o && !mem_ack_i;
         if (mem_req_o && !mem_ack_i) begin
            if (mem_we_o) bmem[mem_addr_o[11:2]] = mem_wdata_o;
            else mem_rdata_i <= bmem[mem_addr_o[11:2]];
         end
      end
   end

   always @(posedge clk) begin
      if (rst_n) begin
         if (evt_buf_done_o) n_txb++;
         if (evt_frame_done_o) n_txf++;
         if (evt_babble_o) n_bab++;
      end
   end

   // scoreboard monitor with sink back-pressure
   always @(negedge clk) begin
      cyc++;
      tx_ready_i = (cyc % 5) != 3 && (cyc % 7) != 1;
      if (rst_n && tx_valid_o && tx_ready_i) begin
         n_bytes++;
         if (exp_q.size() == 0) begin
            chk(0, "R4", {23'd0, tx_last_o, tx_data_o}, 32'h1ff);
         end else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            chk({tx_last_o, tx_data_o} == e, "R3", {23'd0, tx_last_o, tx_data_o}, {23'd0, e});
         end
         if (tx_last_o) n_frames++;
      end
   end

   task automatic push_bytes(input int addr, input int n, input bit last_at_end);
      for (int i = 0; i < n; i++)
         exp_q.push_back({(last_at_end && i == n - 1), pat(addr + i)});
   endtask

   task automatic put_desc(input int addr, input logic [15:0] flg, input logic [15:0] len, input logic [31:0] bufa);
      bmem[addr >> 2]       = {flg, len};
      bmem[(addr >> 2) + 1] = bufa;
   endtask

   task automatic kick();
      @(negedge clk); kick_i = 1'b1;
      @(negedge clk); kick_i = 1'b0;
   endtask

   task automatic wait_done();
      while (busy_o || exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic set_base(input logic [31:0] v);
      @(negedge clk); ring_base_we_i = 1'b1; ring_base_i = v;
      @(negedge clk); ring_base_we_i = 1'b0;
   endtask

   initial begin
      for (int w = 0; w < 1024; w++)
         bmem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
      for (int w = 0; w < 256; w++) bmem[w] = '0;

      repeat (4) @(negedge clk);
      chk(busy_o == 0, "R1 reset busy", {31'd0, busy_o}, 0);
      chk(tx_valid_o == 0, "R11 reset valid", {31'd0, tx_valid_o}, 0);
      chk(mem_req_o == 0, "R2 reset req", {31'd0, mem_req_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cur_desc_o == 0, "R8 reset pointer", cur_desc_o, 0);

      // R10: activate ignored while disabled
      put_desc(0, 16'h8800, 16'd4, 32'h400);
      begin
         int r0;
         r0 = n_req;
         kick();
         repeat (10) @(negedge clk);
         chk(n_req == r0, "R10 no memory request", n_req, r0);
         chk(busy_o == 0, "R10 busy stays low", {31'd0, busy_o}, 0);
         chk(n_bytes == 0, "R10 no stream", n_bytes, 0);
      end

      // R8: base low bits dropped, pointer loaded
      set_base(32'h103);
      @(negedge clk);
      chk(cur_desc_o == 32'h100, "R8 base alignment", cur_desc_o, 32'h100);
      enable_i = 1'b1;

      // R1 R2 R4 R6: single descriptor frame, unaligned buffer
      put_desc(32'h100, 16'h8800, 16'd5, 32'h401);
      put_desc(32'h108, 16'h0000, 16'd0, 32'h0);
      push_bytes(32'h401, 5, 1);
      kick();
      wait_done();
      chk(n_bytes == 5, "R4 byte count", n_bytes, 5);
      chk(n_frames == 1, "R4 frame count", n_frames, 1);
      chk(cur_desc_o == 32'h108, "R2 stop keeps pointer", cur_desc_o, 32'h108);
      chk(bmem[32'h100 >> 2] == 32'h0800_0005, "R6 write-back word", bmem[32'h100 >> 2], 32'h0800_0005);
      chk(n_txb == 1, "R6 buffer events", n_txb, 1);
      chk(n_txf == 1, "R4 frame events", n_txf, 1);
      chk(n_bab == 0, "R5 no babble", n_bab, 0);

      // R3 R7: gather over two descriptors, second wraps
      put_desc(32'h108, 16'h8000, 16'd3, 32'h410);
      put_desc(32'h110, 16'hA800, 16'd4, 32'h423);
      push_bytes(32'h410, 3, 0);
      push_bytes(32'h423, 4, 1);
      kick();
      wait_done();
      chk(n_bytes == 12, "R3 gathered bytes", n_bytes, 12);
      chk(n_frames == 2, "R3 one frame for two buffers", n_frames, 2);
      chk(cur_desc_o == 32'h100, "R7 wrap to base", cur_desc_o, 32'h100);
      chk(bmem[32'h110 >> 2] == 32'h2800_0004, "R6 wrap write-back", bmem[32'h110 >> 2], 32'h2800_0004);
      chk(bmem[32'h108 >> 2] == 32'h0000_0003, "R6 middle write-back", bmem[32'h108 >> 2], 32'h0000_0003);
      chk(n_txb == 3, "R6 buffer events", n_txb, 3);
      chk(n_txf == 2, "R4 frame events", n_txf, 2);

      // R5: truncation at the frame limit
      set_base(32'h203);
      @(negedge clk);
      chk(cur_desc_o == 32'h200, "R8 rebase while idle", cur_desc_o, 32'h200);
      put_desc(32'h200, 16'h8000, 16'd1200, 32'h400);
      put_desc(32'h208, 16'h8800, 16'd1200, 32'h400);
      put_desc(32'h210, 16'h0000, 16'd0, 32'h0);
      push_bytes(32'h400, 1200, 0);
      push_bytes(32'h400, 848, 1);
      kick();
      wait_done();
      chk(n_bytes == 12 + 2048, "R5 truncated length", n_bytes, 12 + 2048);
      chk(n_bab == 1, "R5 babble event", n_bab, 1);
      chk(n_txf == 3, "R4 frame events", n_txf, 3);
      chk(n_txb == 5, "R6 buffer events", n_txb, 5);
      chk(bmem[32'h208 >> 2] == 32'h0800_04B0, "R6 count kept", bmem[32'h208 >> 2], 32'h0800_04B0);
      chk(cur_desc_o == 32'h210, "R7 linear advance", cur_desc_o, 32'h210);

      // R9: disable rewinds pointer
      @(negedge clk); enable_i = 1'b0;
      repeat (2) @(negedge clk);
      chk(cur_desc_o == 32'h200, "R9 rewind to base", cur_desc_o, 32'h200);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule